// File: doc/BRIEF.md
# SPI Register Self-Test Sequencer

This block exercises an SPI slave through a byte-level SPI master and confirms that register access is reliable over a long run. Each pass of the test has three steps. First it reads a fixed identification register and checks it against a known constant. Then it writes a 30-byte incrementing pattern into a buffer register. Finally it reads that buffer back and checks every byte.

A free-running period timer launches one pass every `PERIOD_CYC` clock cycles. The test covers `DURATION_CYC / PERIOD_CYC` passes in total. The defaults give 50 ms and 10 s at a 50 MHz clock, and a test bench can shrink both figures. The first byte mismatch ends the test and records the step and byte position. The test also ends if a period elapses before the current pass has finished. A clean run ends with the pass flag raised and a full iteration count.

The master side works one byte at a time. The sequencer raises `m_req` for one cycle with the byte to shift out and a flag marking the final byte of the frame. It then waits for the master to pulse `m_done` with the byte that was shifted in.

Top module: `spi_selftest_seq`

## Requirements
- R1: After reset, `busy`, `done` and `pass` are 0, `iter_count`, `fail_step` and `fail_index` are 0, and no byte request is issued until `start` is pulsed.
- R2: Every frame begins with a header byte whose bit 7 is 1 for a write and 0 for a read, bit 6 is 1 when a sub-index byte follows, and bits 5:0 are the register number. The identification read is header 0x00 followed by 4 bytes. Data bytes of a read carry 0x00 on `m_tx`. `m_last` is 1 exactly on the final byte of each frame.
- R3: The 4 bytes returned by the identification read are compared least significant byte first with 0xDECA0130: returned byte k must equal bits 8k+7:8k.
- R4: The write frame is header 0xE1, sub-index 0x00, then the 30 data bytes 0, 1, ... 29 in that order.
- R5: The readback frame is header 0x61, sub-index 0x00, then 30 bytes of 0x00. Returned byte k must equal k.
- R6: Only one byte is outstanding at a time. A new `m_req` is raised only after `m_done` has answered the previous one.
- R7: The first pass starts in the cycle after `start` is taken. Each later pass's identification header is requested exactly `PERIOD_CYC` cycles after the previous one.
- R8: When all `DURATION_CYC / PERIOD_CYC` passes complete with no mismatch, `done` = 1, `pass` = 1, `busy` = 0 and `iter_count` equals that number. No further requests follow.
- R9: On the first mismatch the sequencer stops with `done` = 1 and `pass` = 0. It records `fail_step` = 1 for the identification step or 3 for the readback step, and the failing byte index k in `fail_index`. `iter_count` holds the number of fully completed passes, and no further requests follow.
- R10: If a period elapses while a pass is still in progress, the sequencer stops with `done` = 1, `pass` = 0, `fail_step` = 0 and `fail_index` = 0.
- R11: `start` is ignored while `busy` is 1. A `start` after `done` clears all status and runs the whole test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a test run |
| m_req | output | 1 | One-cycle request to shift one byte |
| m_tx | output | 8 | Byte to shift out with the request |
| m_last | output | 1 | Marks the final byte of a frame (chip select released after it) |
| m_done | input | 1 | One-cycle pulse when the requested byte has been shifted |
| m_rx | input | 8 | Byte shifted in, valid with `m_done` |
| busy | output | 1 | A test run is in progress |
| done | output | 1 | The run has ended |
| pass | output | 1 | The run ended with every pass clean |
| iter_count | output | ITER_W | Number of completed passes |
| fail_step | output | 2 | 0 overrun, 1 identification, 3 readback |
| fail_index | output | IDX_W | Byte index of the first mismatch |

## Verification
The hardest cases to reach from the ports are the period overrun and a mismatch deep inside a later pass. Both need the slave to misbehave at one exact moment after earlier passes have gone cleanly. The bench's slave model keeps the written buffer and answers every read from it. It can corrupt one chosen byte of one chosen pass's readback, or hold back its answer to one pass's header for longer than a period. The identification value can also be made wrong in a single byte, so that the least-significant-first order shows in the reported index.

// File: rtl/spi_selftest_pkg.sv
package spi_selftest_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_GAP,
      ST_HALT,
      ST_FIN
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_ID = 2'd0,
      PH_WR = 2'd1,
      PH_RD = 2'd2
   } seq_phase_e;

   localparam logic [1:0] FAIL_OVERRUN = 2'd0;
   localparam logic [1:0] FAIL_ID      = 2'd1;
   localparam logic [1:0] FAIL_RB      = 2'd3;

   localparam logic [7:0] FILL_BYTE = 8'h00;

   function automatic logic [7:0] make_header(input logic wr, input logic sub, input logic [5:0] regno);
      return {wr, sub, regno};
   endfunction

endpackage

// File: rtl/spi_selftest_timer.sv
module spi_selftest_timer #(
   parameter int PERIOD_CYC = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CNT_W-1:0] WRAP_AT = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] cnt;

   assign tick = en && (cnt == WRAP_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= tick ? '0 : cnt + 1'b1;
      end
   end

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/spi_selftest_frame.sv
module spi_selftest_frame
   import spi_selftest_pkg::*;
#(
   parameter int              PAT_LEN   = 30,
   parameter int              ID_BYTES  = 4,
   parameter logic [5:0]      ID_REG    = 6'h00,
   parameter logic [5:0]      BUF_REG   = 6'h21,
   parameter logic [7:0]      BUF_SUB   = 8'h00,
   parameter logic [8*ID_BYTES-1:0] EXP_ID = 32'hDECA0130,
   parameter bit              LSB_FIRST = 1'b1,
   parameter int              POS_W     = 6,
   parameter int              IDX_W     = 5
) (
   input  seq_phase_e       phase,
   input  logic [POS_W-1:0] pos,
   output logic [7:0]       tx,
   output logic             last,
   output logic             cmp_en,
   output logic [7:0]       cmp_byte,
   output logic [IDX_W-1:0] idx
);
   localparam int ID_LEN  = 1 + ID_BYTES;
   localparam int BUF_LEN = 2 + PAT_LEN;
   localparam logic [7:0] HDR_ID = make_header(1'b0, 1'b0, ID_REG);
   localparam logic [7:0] HDR_WR = make_header(1'b1, 1'b1, BUF_REG);
   localparam logic [7:0] HDR_RD = make_header(1'b0, 1'b1, BUF_REG);
   localparam logic [POS_W-1:0] ID_END  = POS_W'(ID_LEN - 1);
   localparam logic [POS_W-1:0] BUF_END = POS_W'(BUF_LEN - 1);

   logic [POS_W-1:0] id_k;
   logic [POS_W-1:0] dat_k;
   logic [7:0]       id_sel;

   assign id_k  = (pos == '0) ? '0 : POS_W'(pos - 1'b1);
   assign dat_k = (pos < POS_W'(2)) ? '0 : POS_W'(pos - 2'd2);

   if (LSB_FIRST) begin : g_lsb_first
      assign id_sel = EXP_ID[8*int'(id_k) +: 8];
   end else begin : g_msb_first
      assign id_sel = EXP_ID[8*(ID_BYTES-1-int'(id_k)) +: 8];
   end

   always_comb begin
      tx       = FILL_BYTE;
      last     = 1'b0;
      cmp_en   = 1'b0;
      cmp_byte = 8'h00;
      idx      = '0;
      unique case (phase)
         PH_ID: begin
            last = (pos == ID_END);
            if (pos == '0) begin
               tx = HDR_ID;
            end else begin
               cmp_en   = 1'b1;
               cmp_byte = id_sel;
               idx      = IDX_W'(id_k);
            end
         end
         PH_WR: begin
            last = (pos == BUF_END);
            if (pos == '0)
               tx = HDR_WR;
            else if (pos == POS_W'(1))
               tx = BUF_SUB;
            else
               tx = 8'(dat_k);
         end
         PH_RD: begin
            last = (pos == BUF_END);
            if (pos == '0) begin
               tx = HDR_RD;
            end else if (pos == POS_W'(1)) begin
               tx = BUF_SUB;
            end else begin
               cmp_en   = 1'b1;
               cmp_byte = 8'(dat_k);
               idx      = IDX_W'(dat_k);
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/spi_selftest_ctrl.sv
module spi_selftest_ctrl
   import spi_selftest_pkg::*;
#(
   parameter int NUM_ITER = 200,
   parameter int ITER_W   = 8,
   parameter int POS_W    = 6,
   parameter int IDX_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             m_done,
   input  logic [7:0]       m_rx,
   input  logic             f_last,
   input  logic             f_cmp_en,
   input  logic [7:0]       f_cmp_byte,
   input  logic [IDX_W-1:0] f_idx,
   output seq_phase_e       phase,
   output logic [POS_W-1:0] pos,
   output logic             m_req,
   output logic             tmr_clr,
   output logic             tmr_en,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic [ITER_W-1:0] iter_count,
   output logic [1:0]       fail_step,
   output logic [IDX_W-1:0] fail_index
);
   localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(NUM_ITER - 1);

   seq_state_e state;
   logic       idle_like;
   logic       mism;

   assign idle_like = (state == ST_IDLE) || (state == ST_HALT) || (state == ST_FIN);
   assign m_req     = (state == ST_ISSUE);
   assign busy      = (state == ST_ISSUE) || (state == ST_WAIT) || (state == ST_GAP);
   assign done      = (state == ST_HALT) || (state == ST_FIN);
   assign pass      = (state == ST_FIN);
   assign tmr_clr   = idle_like && start;
   assign tmr_en    = busy;
   assign mism      = f_cmp_en && (m_rx != f_cmp_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= PH_ID;
         pos        <= '0;
         iter_count <= '0;
         fail_step  <= FAIL_OVERRUN;
         fail_index <= '0;
      end else begin
         unique case (state)
            ST_IDLE, ST_HALT, ST_FIN: begin
               if (start) begin
                  state      <= ST_ISSUE;
                  phase      <= PH_ID;
                  pos        <= '0;
                  iter_count <= '0;
                  fail_step  <= FAIL_OVERRUN;
                  fail_index <= '0;
               end
            end
            ST_ISSUE: begin
               if (tick) begin
                  state      <= ST_HALT;
                  fail_step  <= FAIL_OVERRUN;
                  fail_index <= '0;
               end else begin
                  state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (tick) begin
                  state      <= ST_HALT;
                  fail_step  <= FAIL_OVERRUN;
                  fail_index <= '0;
               end else if (m_done) begin
                  if (mism) begin
                     state      <= ST_HALT;
                     fail_step  <= (phase == PH_ID) ? FAIL_ID : FAIL_RB;
                     fail_index <= f_idx;
                  end else if (f_last) begin
                     pos <= '0;
                     unique case (phase)
                        PH_ID: begin
                           phase <= PH_WR;
                           state <= ST_ISSUE;
                        end
                        PH_WR: begin
                           phase <= PH_RD;
                           state <= ST_ISSUE;
                        end
                        default: begin
                           phase      <= PH_ID;
                           iter_count <= iter_count + 1'b1;
                           state      <= (iter_count == LAST_ITER) ? ST_FIN : ST_GAP;
                        end
                     endcase
                  end else begin
                     pos   <= pos + 1'b1;
                     state <= ST_ISSUE;
                  end
               end
            end
            ST_GAP: begin
               if (tick)
                  state <= ST_ISSUE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Tracks a byte handed to the master and not yet answered.
   logic outst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         outst <= 1'b0;
      else if (m_req)
         outst <= 1'b1;
      else if (m_done)
         outst <= 1'b0;
   end

   // R6
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |-> !outst);

   // R8
   pass_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> (iter_count == ITER_W'(NUM_ITER)));

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !m_req);

   // R8
   iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && (iter_count != $past(iter_count))) |-> (iter_count == $past(iter_count) + 1'b1));

endmodule

// File: rtl/spi_selftest_seq.sv
module spi_selftest_seq
   import spi_selftest_pkg::*;
#(
   parameter int              PERIOD_CYC   = 2_500_000,
   parameter int              DURATION_CYC = 500_000_000,
   parameter int              PAT_LEN      = 30,
   parameter int              ID_BYTES     = 4,
   parameter logic [5:0]      ID_REG       = 6'h00,
   parameter logic [5:0]      BUF_REG      = 6'h21,
   parameter logic [7:0]      BUF_SUB      = 8'h00,
   parameter logic [8*ID_BYTES-1:0] EXP_ID = 32'hDECA0130,
   parameter bit              LSB_FIRST    = 1'b1,
   localparam int NUM_ITER = DURATION_CYC / PERIOD_CYC,
   localparam int ITER_W   = $clog2(NUM_ITER + 1),
   localparam int POS_W    = $clog2(PAT_LEN + 3),
   localparam int IDX_W    = $clog2((PAT_LEN > ID_BYTES) ? PAT_LEN : ID_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              m_req,
   output logic [7:0]        m_tx,
   output logic              m_last,
   input  logic              m_done,
   input  logic [7:0]        m_rx,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic [ITER_W-1:0] iter_count,
   output logic [1:0]        fail_step,
   output logic [IDX_W-1:0]  fail_index
);
   if (PERIOD_CYC < 2) begin : g_bad_period
      $error("PERIOD_CYC must be at least 2");
   end
   if (DURATION_CYC < PERIOD_CYC) begin : g_bad_duration
      $error("DURATION_CYC must cover at least one period");
   end
   if ((PAT_LEN < 2) || (PAT_LEN > 255)) begin : g_bad_pattern
      $error("PAT_LEN must lie in 2..255");
   end
   if (ID_BYTES < 1) begin : g_bad_id
      $error("ID_BYTES must be at least 1");
   end

   seq_phase_e       phase;
   logic [POS_W-1:0] pos;
   logic             tick, tmr_clr, tmr_en;
   logic             f_cmp_en;
   logic [7:0]       f_cmp_byte;
   logic [IDX_W-1:0] f_idx;

   spi_selftest_timer #(
      .PERIOD_CYC(PERIOD_CYC)
   ) timer_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tmr_clr),
      .en   (tmr_en),
      .tick (tick)
   );

   spi_selftest_frame #(
      .PAT_LEN  (PAT_LEN),
      .ID_BYTES (ID_BYTES),
      .ID_REG   (ID_REG),
      .BUF_REG  (BUF_REG),
      .BUF_SUB  (BUF_SUB),
      .EXP_ID   (EXP_ID),
      .LSB_FIRST(LSB_FIRST),
      .POS_W    (POS_W),
      .IDX_W    (IDX_W)
   ) frame_i (
      .phase   (phase),
      .pos     (pos),
      .tx      (m_tx),
      .last    (m_last),
      .cmp_en  (f_cmp_en),
      .cmp_byte(f_cmp_byte),
      .idx     (f_idx)
   );

   spi_selftest_ctrl #(
      .NUM_ITER(NUM_ITER),
      .ITER_W  (ITER_W),
      .POS_W   (POS_W),
      .IDX_W   (IDX_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tick      (tick),
      .m_done    (m_done),
      .m_rx      (m_rx),
      .f_last    (m_last),
      .f_cmp_en  (f_cmp_en),
      .f_cmp_byte(f_cmp_byte),
      .f_idx     (f_idx),
      .phase     (phase),
      .pos       (pos),
      .m_req     (m_req),
      .tmr_clr   (tmr_clr),
      .tmr_en    (tmr_en),
      .busy      (busy),
      .done      (done),
      .pass      (pass),
      .iter_count(iter_count),
      .fail_step (fail_step),
      .fail_index(fail_index)
   );

endmodule

// File: tb/spi_selftest_seq_tb_top.sv
module spi_selftest_seq_tb_top;
   localparam int PERIOD   = 800;
   localparam int DURATION = 4000;
   localparam int NITER    = DURATION / PERIOD;
   localparam int LAT      = 2;
   localparam int STALL    = 1000;
   localparam int ITER_W   = 3;
   localparam int IDX_W    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic m_done = 1'b0;
   logic [7:0] m_rx = 8'h00;
   logic m_req, m_last, busy, done, pass;
   logic [7:0] m_tx;
   logic [ITER_W-1:0] iter_count;
   logic [1:0] fail_step;
   logic [IDX_W-1:0] fail_index;

   always #10 clk = ~clk;

   spi_selftest_seq #(
      .PERIOD_CYC  (PERIOD),
      .DURATION_CYC(DURATION)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .m_req(m_req), .m_tx(m_tx), .m_last(m_last),
      .m_done(m_done), .m_rx(m_rx),
      .busy(busy), .done(done), .pass(pass),
      .iter_count(iter_count), .fail_step(fail_step), .fail_index(fail_index)
   );

   int errors = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0] tx;
      logic       last;
      logic [3:0] rq;
   } exp_t;

   exp_t q[$];

   function automatic exp_t mk(input logic [7:0] tx, input logic last, input logic [3:0] rq);
      exp_t e;
      e.tx = tx; e.last = last; e.rq = rq;
      return e;
   endfunction

   function automatic string tagname(input logic [3:0] rq);
      case (rq)
         4'd4:    return "R4";
         4'd5:    return "R5";
         default: return "R2";
      endcase
   endfunction

   // Driver: expected byte stream of one pass.
   task automatic push_iter();
      q.push_back(mk(8'h00, 1'b0, 4'd2));
      for (int k = 0; k < 4; k++) q.push_back(mk(8'h00, k == 3, 4'd2));
      q.push_back(mk(8'hE1, 1'b0, 4'd4));
      q.push_back(mk(8'h00, 1'b0, 4'd4));
      for (int k = 0; k < 30; k++) q.push_back(mk(8'(k), k == 29, 4'd4));
      q.push_back(mk(8'h61, 1'b0, 4'd5));
      q.push_back(mk(8'h00, 1'b0, 4'd5));
      for (int k = 0; k < 30; k++) q.push_back(mk(8'h00, k == 29, 4'd5));
   endtask

   // Slave model and monitor state
   logic [31:0] id_val = 32'hDECA0130;
   logic [7:0]  mem [30];
   logic [7:0]  hdr = 8'h00;
   int fpos = 0;
   int iter_seen = 0;
   int rb_iter = -1;
   int rb_idx = 0;
   int stall_iter = -1;
   bit pend = 0;
   int wcnt = 0;
   logic [7:0] rx_hold = 8'h00;
   longint cyc = 0;
   longint last_hdr = 0;
   bit hdr_seen = 0;
   int req_cnt = 0;

   always @(negedge clk) begin : monitor
      int lat;
      int off;
      logic [7:0] rx;
      exp_t e;
      cyc++;
      m_done = 1'b0;
      if (pend) begin
         if (wcnt == 0) begin
            m_done = 1'b1;
            m_rx   = rx_hold;
            pend   = 1'b0;
         end else begin
            wcnt--;
         end
      end
      if (m_req) begin
         req_cnt++;
         chk(!pend, "R6", "request while byte outstanding", longint'(pend), 0);
         lat = LAT;
         rx  = 8'h00;
         if (q.size() == 0) begin
            chk(1'b0, "R9", "unexpected request", longint'(m_tx), 0);
         end else begin
            e = q.pop_front();
            chk(m_tx == e.tx, tagname(e.rq), "tx byte", longint'(m_tx), longint'(e.tx));
            chk(m_last == e.last, tagname(e.rq), "last flag", longint'(m_last), longint'(e.last));
         end
         if (fpos == 0) begin
            hdr = m_tx;
            if (m_tx == 8'h00) begin
               iter_seen++;
               if (hdr_seen)
                  chk(cyc - last_hdr == PERIOD, "R7", "launch spacing", cyc - last_hdr, PERIOD);
               hdr_seen = 1'b1;
               last_hdr = cyc;
               if (iter_seen - 1 == stall_iter) lat = STALL;
            end
         end else begin
            off = fpos - (hdr[6] ? 2 : 1);
            if (hdr == 8'h00) begin
               if (off < 4) rx = id_val[8*off +: 8];
            end else if (hdr[7]) begin
               if (off >= 0 && off < 30) mem[off] = m_tx;
            end else if (hdr[6] && off >= 0 && off < 30) begin
               rx = mem[off];
               if (iter_seen - 1 == rb_iter && off == rb_idx) rx = rx ^ 8'h5A;
            end
         end
         if (m_last) fpos = 0; else fpos++;
         pend    = 1'b1;
         wcnt    = lat;
         rx_hold = rx;
      end
   end

   task automatic run_start();
      q.delete();
      for (int i = 0; i < NITER; i++) push_iter();
      iter_seen = 0;
      fpos      = 0;
      hdr_seen  = 1'b0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int n = 0; n < 20000; n++) begin
         @(negedge clk);
         if (done) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic quiet(input string tag);
      int rc;
      rc = req_cnt;
      repeat (1000) @(negedge clk);
      chk(req_cnt == rc, tag, "requests after done", req_cnt - rc, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin : stim
      bit ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(pass == 1'b0, "R1", "pass after reset", pass, 0);
      chk(iter_count == 0 && fail_step == 0 && fail_index == 0, "R1", "status after reset",
          {iter_count, fail_step, fail_index}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(req_cnt == 0, "R1", "requests before start", req_cnt, 0);

      // Clean run with an ignored start in the middle (R8, R11, R3)
      run_start();
      repeat (1000) @(negedge clk);
      chk(busy == 1'b1, "R11", "busy mid run", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk(ok, "R8", "run finished", ok, 1);
      chk(pass == 1'b1, "R8", "pass flag (R3 identification accepted)", pass, 1);
      chk(iter_count == NITER, "R8", "iteration count", iter_count, NITER);
      chk(busy == 1'b0, "R8", "busy at end", busy, 0);
      quiet("R8");

      // Identification byte 1 wrong
      id_val = 32'hDECA0230;
      run_start();
      wait_done(ok);
      chk(ok && pass == 1'b0, "R3", "id mismatch ends failing", pass, 0);
      chk(fail_step == 2'd1, "R3", "fail step id", fail_step, 1);
      chk(fail_index == 1, "R3", "fail index byte1", fail_index, 1);
      chk(iter_count == 0, "R9", "iterations before id fail", iter_count, 0);
      quiet("R9");

      // Identification byte 3 wrong: least significant byte first order
      id_val = 32'hDFCA0130;
      run_start();
      wait_done(ok);
      chk(ok && fail_step == 2'd1, "R3", "fail step id msb", fail_step, 1);
      chk(fail_index == 3, "R3", "fail index byte3", fail_index, 3);
      id_val = 32'hDECA0130;

      // Readback mismatch in pass 2 at byte 17
      rb_iter = 2;
      rb_idx  = 17;
      run_start();
      wait_done(ok);
      chk(ok && pass == 1'b0, "R9", "readback mismatch fails", pass, 0);
      chk(fail_step == 2'd3, "R5", "fail step readback", fail_step, 3);
      chk(fail_index == 17, "R5", "fail index readback", fail_index, 17);
      chk(iter_count == 2, "R9", "iterations before readback fail", iter_count, 2);
      quiet("R9");
      rb_iter = -1;

      // Period overrun: slave holds back pass 1 header answer
      stall_iter = 1;
      run_start();
      wait_done(ok);
      chk(ok && pass == 1'b0, "R10", "overrun fails", pass, 0);
      chk(fail_step == 2'd0, "R10", "fail step overrun", fail_step, 0);
      chk(fail_index == 0, "R10", "fail index overrun", fail_index, 0);
      chk(iter_count == 1, "R10", "iterations before overrun", iter_count, 1);
      repeat (1500) @(negedge clk);
      stall_iter = -1;

      // Restart after failure clears status
      run_start();
      @(negedge clk);
      chk(done == 1'b0 && fail_step == 0 && iter_count == 0, "R11", "status cleared on restart",
          {done, fail_step, iter_count}, 0);
      wait_done(ok);
      chk(ok && pass == 1'b1, "R11", "rerun passes", pass, 1);
      chk(iter_count == NITER, "R11", "rerun iteration count", iter_count, NITER);
      chk(fail_index == 0, "R11", "rerun fail index", fail_index, 0);

      summary();
      $finish;
   end

endmodule